// File: doc/BRIEF.md
# Oscillator clock switch sequencer

This block decides when the system clock moves from one oscillator to another. Software writes a control word that holds a 3-bit requested-source code and a start bit. The sequencer first rejects requests that would change nothing or that are not allowed. For an accepted request it turns on the requested oscillator. It then waits for the crystal start-up timer and the PLL lock where these apply, and counts a fixed number of cycles of the new clock. After that it hands the clock select over. At handover it records the new current source, clears the start bit and releases the old oscillator, unless a keep-alive condition holds that oscillator on.

The analog oscillators and the PLL are outside the block. Their ready and lock indications come in as inputs. The edges of each source arrive as per-source tick strobes in the control clock domain. A configuration input can disable switching. While switching is disabled, the current source follows the boot selection and the start bit stays clear.

Source codes: 0 = fast RC, 1 = fast RC with PLL, 2 = primary, 3 = primary with PLL, 4 = low-power crystal, 5 = low-power RC, 6 and 7 are reserved. Physical enable bits: 0 = fast RC, 1 = primary, 2 = low-power crystal, 3 = low-power RC.

Top module: `osw_seq`

## Requirements
- R1: After reset, and whenever `sw_en_cfg_i` is 0, the current-source field (control bits 14:12) equals `boot_src_i`. While switching is disabled, the start bit (control bit 0) reads 0 and a write never makes `busy_o` rise.
- R2: A request whose code equals the current source clears the start bit, never raises `busy_o`, and leaves the current source unchanged.
- R3: A request to a reserved code (6, 7), or a direct request between code 1 and code 3 in either direction, is aborted in the same way as R2.
- R4: When a valid request starts, the LOCK bit (bit 5) and the clock-fail bit (bit 3) are cleared, `busy_o` rises, and the target's enable bit in `osc_en_o` is set.
- R5: A target that is a crystal (codes 2, 3, 4) holds the switch until `osc_rdy_i` of its physical source is 1.
- R6: A PLL target (codes 1, 3) holds the switch until `pll_lock_i` is 1. LOCK then reads 1.
- R7: After readiness, the switch completes on the tenth tick of the target's `src_tick_i`. With ready, lock and ticks all held at 1, `busy_o` is high for exactly 12 cycles.
- R8: On completion the start bit reads 0, the current-source field and `clk_sel_o` equal the requested code, and the old oscillator's enable bit drops.
- R9: The low-power RC enable stays on while `wdt_on_i` is 1. The low-power crystal enable stays on while `lp_keep_i` is 1.
- R10: Control writes made while a switch is in progress are ignored: both the requested field and the final source stay as they were.
- R11: A pulse on `clk_fail_i` sets the clock-fail bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_en_cfg_i | input | 1 | 1 = clock switching allowed |
| boot_src_i | input | 3 | Configured boot source code |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 16 | Control word: bits 10:8 requested code, bit 0 start |
| ctl_q_o | output | 16 | Control/status readback |
| osc_rdy_i | input | 4 | Per-source start-up timer expired |
| pll_lock_i | input | 1 | PLL lock indication |
| src_tick_i | input | 4 | Per-source clock edge strobe |
| clk_fail_i | input | 1 | Clock failure event |
| wdt_on_i | input | 1 | Watchdog or fail-safe monitor on |
| lp_keep_i | input | 1 | Keep low-power crystal running |
| osc_en_o | output | 4 | Per-source oscillator enable |
| pll_en_o | output | 1 | PLL enable |
| clk_sel_o | output | 3 | Clock mux select code |
| busy_o | output | 1 | Switch in progress |

## Verification
Assertions check, on every cycle, the properties that hold at all times. The start bit stays low while switching is disabled. Redundant and forbidden requests go back to idle. Starting a switch clears LOCK and the clock-fail bit. A missing crystal-ready input holds the wait state. The settle phase is never reached for a PLL target without LOCK. The requested field is frozen while the block is busy. The settle counter stays in range, and completion copies the request into the current source.

The bench sweeps every source pair, including the reserved codes. It checks the exact busy length, the final source and the enable pattern for each pair. Only these scenarios can show the end-to-end stalls on missing ready, lock or ticks, the keep-alive enables after handover, and that a write made mid-switch has no effect.

// File: rtl/osw_pkg.sv
package osw_pkg;

   localparam int SRC_W  = 3;
   localparam int NPHYS  = 4;
   localparam int CTL_W  = 16;

   typedef logic [SRC_W-1:0] src_code_t;

   localparam src_code_t SRC_FRC     = 3'd0;
   localparam src_code_t SRC_FRC_PLL = 3'd1;
   localparam src_code_t SRC_PRI     = 3'd2;
   localparam src_code_t SRC_PRI_PLL = 3'd3;
   localparam src_code_t SRC_LPX     = 3'd4;
   localparam src_code_t SRC_LPRC    = 3'd5;

   localparam int PH_FRC  = 0;
   localparam int PH_PRI  = 1;
   localparam int PH_LPX  = 2;
   localparam int PH_LPRC = 3;

   // control word bit positions (decoded by software)
   localparam int B_COSC_LO = 12;
   localparam int B_NOSC_LO = 8;
   localparam int B_LOCK    = 5;
   localparam int B_CF      = 3;
   localparam int B_GO      = 0;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_WAIT_OSC,
      SQ_WAIT_LOCK,
      SQ_SETTLE
   } sq_state_t;

   function automatic logic [1:0] src_phys(input src_code_t c);
      case (c)
         SRC_PRI, SRC_PRI_PLL: src_phys = 2'(PH_PRI);
         SRC_LPX:              src_phys = 2'(PH_LPX);
         SRC_LPRC:             src_phys = 2'(PH_LPRC);
         default:              src_phys = 2'(PH_FRC);
      endcase
   endfunction

   function automatic logic src_has_pll(input src_code_t c);
      src_has_pll = (c == SRC_FRC_PLL) || (c == SRC_PRI_PLL);
   endfunction

   function automatic logic src_known(input src_code_t c);
      src_known = (c <= SRC_LPRC);
   endfunction

endpackage

// File: rtl/osw_gate.sv
module osw_gate
   import osw_pkg::*;
(
   input  src_code_t cur_i,
   input  src_code_t req_i,
   output logic      redundant_o,
   output logic      illegal_o
);

   logic pll_cross;

   always_comb begin
      pll_cross   = ((cur_i == SRC_FRC_PLL) && (req_i == SRC_PRI_PLL)) ||
                    ((cur_i == SRC_PRI_PLL) && (req_i == SRC_FRC_PLL));
      redundant_o = (cur_i == req_i);
      illegal_o   = pll_cross || !src_known(req_i);
   end

endmodule

// File: rtl/osw_settle.sv
module osw_settle #(
   parameter int SETTLE_CYC = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic tick_i,
   output logic done_o
);

   localparam int CNT_W = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

   logic [CNT_W-1:0] cnt_q;

   initial begin
      assert (SETTLE_CYC >= 1) else $error("SETTLE_CYC must be at least 1");
   end

   assign done_o = run_i && tick_i && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run_i || done_o) begin
         cnt_q <= '0;
      end else if (tick_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

   p_cnt_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/osw_src_en.sv
module osw_src_en
   import osw_pkg::*;
(
   input  src_code_t          cur_i,
   input  src_code_t          nxt_i,
   input  logic               switching_i,
   input  logic               wdt_on_i,
   input  logic               lp_keep_i,
   output logic [NPHYS-1:0]   osc_en_o,
   output logic               pll_en_o
);

   logic [1:0] cur_ph;
   logic [1:0] nxt_ph;

   assign cur_ph   = src_phys(cur_i);
   assign nxt_ph   = src_phys(nxt_i);
   assign pll_en_o = src_has_pll(cur_i) || (switching_i && src_has_pll(nxt_i));

   for (genvar i = 0; i < NPHYS; i++) begin : g_en
      logic keep;
      if (i == PH_LPRC) begin : g_k_lprc
         assign keep = wdt_on_i;
      end else if (i == PH_LPX) begin : g_k_lpx
         assign keep = lp_keep_i;
      end else begin : g_k_none
         assign keep = 1'b0;
      end
      assign osc_en_o[i] = (cur_ph == 2'(i)) || (switching_i && (nxt_ph == 2'(i))) || keep;
   end

endmodule

// File: rtl/osw_seq.sv
module osw_seq
   import osw_pkg::*;
#(
   parameter int SETTLE_CYC  = 10,
   parameter bit PRI_IS_XTAL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_en_cfg_i,
   input  logic [2:0]        boot_src_i,
   input  logic              wr_en_i,
   input  logic [15:0]       wr_data_i,
   output logic [15:0]       ctl_q_o,
   input  logic [3:0]        osc_rdy_i,
   input  logic              pll_lock_i,
   input  logic [3:0]        src_tick_i,
   input  logic              clk_fail_i,
   input  logic              wdt_on_i,
   input  logic              lp_keep_i,
   output logic [3:0]        osc_en_o,
   output logic              pll_en_o,
   output logic [2:0]        clk_sel_o,
   output logic              busy_o
);

   initial begin
      assert (CTL_W == 16) else $error("control word must be 16 bits");
      assert (NPHYS == 4) else $error("four physical sources expected");
   end

   sq_state_t state_q;
   src_code_t cosc_q, nosc_q;
   logic      go_q, lock_q, cf_q;

   logic       redundant, illegal;
   logic [1:0] new_ph;
   logic       xtal_new, pll_new, settle_done;
   src_code_t  wr_code;
   logic       unused_wr;

   assign wr_code   = wr_data_i[B_NOSC_LO +: SRC_W];
   assign unused_wr = ^{wr_data_i[15:11], wr_data_i[7:1]};
   assign new_ph    = src_phys(nosc_q);
   assign pll_new   = src_has_pll(nosc_q);

   if (PRI_IS_XTAL) begin : g_pri_xtal
      assign xtal_new = (new_ph == 2'(PH_PRI)) || (new_ph == 2'(PH_LPX));
   end else begin : g_pri_ext
      assign xtal_new = (new_ph == 2'(PH_LPX));
   end

   osw_gate u_gate (
      .cur_i       (cosc_q),
      .req_i       (nosc_q),
      .redundant_o (redundant),
      .illegal_o   (illegal)
   );

   osw_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (state_q == SQ_SETTLE),
      .tick_i (src_tick_i[new_ph]),
      .done_o (settle_done)
   );

   osw_src_en u_src_en (
      .cur_i       (cosc_q),
      .nxt_i       (nosc_q),
      .switching_i (busy_o),
      .wdt_on_i    (wdt_on_i),
      .lp_keep_i   (lp_keep_i),
      .osc_en_o    (osc_en_o),
      .pll_en_o    (pll_en_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         cosc_q  <= boot_src_i;
         nosc_q  <= boot_src_i;
         go_q    <= 1'b0;
         lock_q  <= 1'b0;
         cf_q    <= 1'b0;
      end else begin
         if (clk_fail_i) cf_q <= 1'b1;
         if (!sw_en_cfg_i) begin
            state_q <= SQ_IDLE;
            cosc_q  <= boot_src_i;
            go_q    <= 1'b0;
            if (wr_en_i) nosc_q <= wr_code;
         end else begin
            case (state_q)
               SQ_IDLE: begin
                  if (go_q) begin
                     if (redundant || illegal) begin
                        go_q <= 1'b0;
                     end else begin
                        lock_q  <= 1'b0;
                        cf_q    <= 1'b0;
                        state_q <= SQ_WAIT_OSC;
                     end
                  end else if (wr_en_i) begin
                     nosc_q <= wr_code;
                     go_q   <= wr_data_i[B_GO];
                  end
               end
               SQ_WAIT_OSC: begin
                  if (!xtal_new || osc_rdy_i[new_ph]) state_q <= SQ_WAIT_LOCK;
               end
               SQ_WAIT_LOCK: begin
                  if (!pll_new || pll_lock_i) begin
                     lock_q  <= pll_new;
                     state_q <= SQ_SETTLE;
                  end
               end
               default: begin
                  if (settle_done) begin
                     cosc_q  <= nosc_q;
                     go_q    <= 1'b0;
                     state_q <= SQ_IDLE;
                  end
               end
            endcase
         end
      end
   end

   assign busy_o    = (state_q != SQ_IDLE);
   assign clk_sel_o = cosc_q;

   always_comb begin
      ctl_q_o                           = '0;
      ctl_q_o[B_COSC_LO +: SRC_W]       = cosc_q;
      ctl_q_o[B_NOSC_LO +: SRC_W]       = nosc_q;
      ctl_q_o[B_LOCK]                   = lock_q;
      ctl_q_o[B_CF]                     = cf_q;
      ctl_q_o[B_GO]                     = go_q;
   end

   p_dis_go_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_en_cfg_i |=> !go_q && (state_q == SQ_IDLE));

   p_redundant_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_en_cfg_i && state_q == SQ_IDLE && go_q && redundant)
      |=> (state_q == SQ_IDLE) && !go_q);

   p_illegal_abort_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_en_cfg_i && state_q == SQ_IDLE && go_q && illegal)
      |=> (state_q == SQ_IDLE) && !go_q);

   p_start_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_en_cfg_i && state_q == SQ_IDLE && go_q && !redundant && !illegal)
      |=> !lock_q && !cf_q && busy_o);

   p_osc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_en_cfg_i && state_q == SQ_WAIT_OSC && xtal_new && !osc_rdy_i[new_ph])
      |=> (state_q == SQ_WAIT_OSC));

   p_lock_before_settle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_SETTLE && pll_new) |-> lock_q);

   p_done_moves_cosc_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_en_cfg_i && state_q == SQ_SETTLE && settle_done)
      |=> (cosc_q == $past(nosc_q)) && !go_q);

   p_nosc_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_en_cfg_i && busy_o) |=> $stable(nosc_q));

endmodule

// File: tb/osw_seq_bench.sv
module osw_seq_bench;

   localparam int N = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sw_en_cfg = 1'b1;
   logic [2:0]  boot_src = 3'd0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] ctl_q;
   logic [3:0]  osc_rdy = 4'hF;
   logic        pll_lock = 1'b1;
   logic [3:0]  src_tick = 4'hF;
   logic        clk_fail = 1'b0;
   logic        wdt_on = 1'b0;
   logic        lp_keep = 1'b0;
   logic [3:0]  osc_en;
   logic        pll_en;
   logic [2:0]  clk_sel;
   logic        busy;

   int total = 0;
   int fails = 0;
   int cyc = 0;
   bit done = 1'b0;
   int cur = 0;

   always #10ns clk = ~clk;

   osw_seq #(.SETTLE_CYC(N)) u_osw_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .sw_en_cfg_i (sw_en_cfg),
      .boot_src_i  (boot_src),
      .wr_en_i     (wr_en),
      .wr_data_i   (wr_data),
      .ctl_q_o     (ctl_q),
      .osc_rdy_i   (osc_rdy),
      .pll_lock_i  (pll_lock),
      .src_tick_i  (src_tick),
      .clk_fail_i  (clk_fail),
      .wdt_on_i    (wdt_on),
      .lp_keep_i   (lp_keep),
      .osc_en_o    (osc_en),
      .pll_en_o    (pll_en),
      .clk_sel_o   (clk_sel),
      .busy_o      (busy)
   );

   function automatic int phys(input int c);
      if (c == 2 || c == 3) return 1;
      if (c == 4) return 2;
      if (c == 5) return 3;
      return 0;
   endfunction

   task automatic report();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   endtask

   task automatic chk(input string tag, input int got, input int exp);
      total++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s got %0h exp %0h", tag, got, exp);
      end
   endtask

   task automatic wr_req(input int code);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = '0;
      wr_data[10:8] = code[2:0];
      wr_data[0]    = 1'b1;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic count_busy(input int n, output int bc);
      bc = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (busy) bc++;
      end
   endtask

   task automatic switch_to(input int code);
      int bc;
      wr_req(code);
      count_busy(N + 8, bc);
      cur = code;
   endtask

   task automatic goto_src(input int code);
      if (cur == code) return;
      if ((cur == 1 && code == 3) || (cur == 3 && code == 1)) switch_to(0);
      if (cur != code) switch_to(code);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         total++;
         fails++;
         $display("FAIL watchdog got %0d exp 0", cyc);
         report();
      end
   end

   initial begin
      int bc;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk("R1 reset ctl", ctl_q, 16'h0000);
      chk("R1 reset en", osc_en, 4'b0001);
      chk("R1 reset busy", busy, 0);
      chk("R1 reset sel", clk_sel, 0);
      chk("R1 reset pll", pll_en, 0);

      // R1: disabled switching follows boot, ignores start
      sw_en_cfg = 1'b0;
      boot_src  = 3'd5;
      repeat (2) @(negedge clk);
      chk("R1 dis cosc", ctl_q[14:12], 5);
      wr_req(0);
      count_busy(N + 8, bc);
      chk("R1 dis busy", bc, 0);
      chk("R1 dis go", ctl_q[0], 0);
      chk("R1 dis cosc hold", ctl_q[14:12], 5);
      chk("R1 dis en", osc_en, 4'b1000);
      boot_src = 3'd0;
      repeat (2) @(negedge clk);
      chk("R1 dis boot0", ctl_q[14:12], 0);
      sw_en_cfg = 1'b1;
      cur = 0;

      // R2 R3 R7 R8: sweep of all pairs
      for (int f = 0; f < 6; f++) begin
         for (int t = 0; t < 8; t++) begin
            bit abort_exp;
            int exp_c;
            goto_src(f);
            abort_exp = (t == f) || (t > 5) || (f == 1 && t == 3) || (f == 3 && t == 1);
            exp_c = abort_exp ? f : t;
            wr_req(t);
            count_busy(N + 8, bc);
            if (t == f)
               chk($sformatf("R2 busy %0d->%0d", f, t), bc, 0);
            else if (abort_exp)
               chk($sformatf("R3 busy %0d->%0d", f, t), bc, 0);
            else
               chk($sformatf("R7 busy %0d->%0d", f, t), bc, N + 2);
            chk($sformatf("R8 cosc %0d->%0d", f, t), ctl_q[14:12], exp_c);
            chk($sformatf("R8 sel %0d->%0d", f, t), clk_sel, exp_c);
            chk($sformatf("R8 go %0d->%0d", f, t), ctl_q[0], 0);
            chk($sformatf("R8 en %0d->%0d", f, t), osc_en, 1 << phys(exp_c));
            chk($sformatf("R8 pll %0d->%0d", f, t), pll_en, (exp_c == 1 || exp_c == 3) ? 1 : 0);
            cur = exp_c;
         end
      end

      // R5: crystal wait, R10: write during switch ignored
      goto_src(0);
      osc_rdy = 4'b1101;
      wr_req(2);
      repeat (30) @(negedge clk);
      chk("R5 busy held", busy, 1);
      chk("R5 cosc held", ctl_q[14:12], 0);
      chk("R4 target on", osc_en[1], 1);
      wr_req(5);
      chk("R10 nosc kept", ctl_q[10:8], 2);
      osc_rdy = 4'hF;
      count_busy(N + 8, bc);
      chk("R5 cosc done", ctl_q[14:12], 2);
      chk("R10 nosc final", ctl_q[10:8], 2);
      chk("R8 old off", osc_en, 4'b0010);
      cur = 2;

      // R6: PLL lock wait
      pll_lock = 1'b0;
      wr_req(3);
      repeat (30) @(negedge clk);
      chk("R6 busy held", busy, 1);
      chk("R6 lock low", ctl_q[5], 0);
      chk("R6 pll en", pll_en, 1);
      pll_lock = 1'b1;
      count_busy(N + 8, bc);
      chk("R6 cosc done", ctl_q[14:12], 3);
      chk("R6 lock set", ctl_q[5], 1);
      cur = 3;

      // R11: clock fail sets CF
      @(negedge clk);
      clk_fail = 1'b1;
      @(negedge clk);
      clk_fail = 1'b0;
      chk("R11 cf set", ctl_q[3], 1);

      // R4 start clears, R7 tick gating
      src_tick = 4'b1110;
      wr_req(0);
      repeat (3) @(negedge clk);
      chk("R4 lock clr", ctl_q[5], 0);
      chk("R4 cf clr", ctl_q[3], 0);
      chk("R4 busy", busy, 1);
      chk("R4 en both", osc_en, 4'b0011);
      repeat (30) @(negedge clk);
      chk("R7 no ticks busy", busy, 1);
      chk("R7 no ticks cosc", ctl_q[14:12], 3);
      src_tick = 4'hF;
      count_busy(N + 8, bc);
      chk("R7 ticks cosc", ctl_q[14:12], 0);
      cur = 0;

      // R9: keep-alive enables
      wdt_on = 1'b1;
      goto_src(5);
      goto_src(0);
      chk("R9 lprc kept", osc_en, 4'b1001);
      wdt_on = 1'b0;
      @(negedge clk);
      chk("R9 lprc off", osc_en, 4'b0001);
      lp_keep = 1'b1;
      goto_src(4);
      goto_src(0);
      chk("R9 lp kept", osc_en, 4'b0101);
      lp_keep = 1'b0;
      @(negedge clk);
      chk("R9 lp off", osc_en, 4'b0001);

      done = 1'b1;
      report();
   end

endmodule